// File: doc/BRIEF.md
# Two-Deep Receive Mailbox

This block stores accepted receive messages for a single mailbox. A message (identifier, byte count and up to eight data bytes) arrives on a strobed write port. The host sees one visible slot on the read port. A data-updated flag tells the host that the slot holds an unread message. In two-deep mode a hidden backup slot catches one more message while the visible slot is still unread. When the host releases the visible slot, the backup message moves into it at once.

An overwrite-enable input decides what happens when no free storage is left. In two-deep mode it can only replace the backup; the visible slot is never overwritten. In single-slot mode it replaces the visible slot. In both modes an overwrite raises a receiver-overwrite flag, which stays up until the next release. Acceptance filtering and bus access sit outside the block.

Top module: `rx_mailbox2`

## Requirements
- R1: After reset, data_upd_o and rx_ovr_o are 0 and rd_id_o, rd_len_o and rd_data_o are all zero.
- R2: A write while the visible slot is empty loads the message into the visible slot, and data_upd_o is 1 from the next clock.
- R3: In two-deep mode, a write while the visible slot is unread and the backup is empty goes to the backup. The read port does not change and rx_ovr_o stays 0.
- R4: In two-deep mode, a release while the backup is full shows the backup message on the read port from the next clock, with data_upd_o still 1. The backup is then empty.
- R5: A release with no backup message clears data_upd_o on the next clock.
- R6: In two-deep mode, with both slots full and ovr_en_i=0, a write is dropped. The read port is unchanged, rx_ovr_o is unchanged, and the older backup message is the one promoted on the next release.
- R7: In two-deep mode, with both slots full and ovr_en_i=1, a write replaces the backup message and leaves the read port unchanged. It sets rx_ovr_o, and the new message is promoted on the next release.
- R8: rx_ovr_o stays set until a release and is 0 on the clock after any release.
- R9: A write and a release in the same clock act as if the release (with any promotion) came first. The write is then placed by the rules above.
- R10: In single-slot mode (TWO_DEEP=0), a write to an unread slot is dropped when ovr_en_i=0. When ovr_en_i=1 it replaces the visible message and sets rx_ovr_o; data_upd_o stays 1 in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Strobe for an incoming accepted message |
| wr_id_i | input | ID_W | Incoming identifier |
| wr_len_i | input | LEN_W | Incoming byte count |
| wr_data_i | input | 8*DATA_BYTES | Incoming data bytes |
| ovr_en_i | input | 1 | Overwrite enable when no free storage is left |
| release_i | input | 1 | Host release of the visible slot |
| rd_id_o | output | ID_W | Visible slot identifier |
| rd_len_o | output | LEN_W | Visible slot byte count |
| rd_data_o | output | 8*DATA_BYTES | Visible slot data |
| data_upd_o | output | 1 | Visible slot holds an unread message |
| rx_ovr_o | output | 1 | A stored message was overwritten since the last release |

## Verification
The hidden backup has no port of its own. A wrong backup state therefore shows only on the clock after the next release, as the wrong message on the read port or a wrongly set or cleared data_upd_o. A wrong visible-slot state or flag shows on the read port or the flags one clock after the write or release that caused it. The bench runs a long mixed sequence of writes and releases, issues a release often, and compares both mode variants with an arithmetic model on every clock. A corrupted backup therefore becomes visible within a few cycles.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    VIS_HOLD = 2'd0,
    VIS_BAK  = 2'd1,
    VIS_NEW  = 2'd2
  } vis_sel_e;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/mbx_disposition.sv
module mbx_disposition
  import mbx_pkg::*;
#(
  parameter bit TWO_DEEP = 1'b1
) (
  input  logic     vis_full_i,
  input  logic     bak_full_i,
  input  logic     rel_i,
  input  logic     wr_i,
  input  logic     ovr_en_i,
  output vis_sel_e vis_sel_o,
  output logic     bak_load_o,
  output logic     vis_full_d_o,
  output logic     bak_full_d_o,
  output logic     ovr_set_o
);
  logic vf, bf, promote;

  // release resolves first, then the write is placed
  always_comb begin
    promote      = TWO_DEEP && rel_i && bak_full_i;
    vf           = rel_i ? promote : vis_full_i;
    bf           = rel_i ? 1'b0 : (TWO_DEEP && bak_full_i);
    vis_sel_o    = promote ? VIS_BAK : VIS_HOLD;
    bak_load_o   = 1'b0;
    vis_full_d_o = vf;
    bak_full_d_o = bf;
    ovr_set_o    = 1'b0;
    if (wr_i) begin
      if (!vf) begin
        vis_sel_o    = VIS_NEW;
        vis_full_d_o = 1'b1;
      end else if (TWO_DEEP) begin
        if (!bf) begin
          bak_load_o   = 1'b1;
          bak_full_d_o = 1'b1;
        end else if (ovr_en_i) begin
          bak_load_o = 1'b1;
          ovr_set_o  = 1'b1;
        end
      end else if (ovr_en_i) begin
        vis_sel_o = VIS_NEW;
        ovr_set_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_mailbox2.sv
module rx_mailbox2
  import mbx_pkg::*;
#(
  parameter int ID_W       = 29,
  parameter int DATA_BYTES = 8,
  parameter bit TWO_DEEP   = 1'b1,
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int LEN_W     = $clog2(DATA_BYTES + 1),
  localparam int MSG_W     = LEN_W + ID_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ovr_en_i,
  input  logic              release_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              data_upd_o,
  output logic              rx_ovr_o
);
  logic [MSG_W-1:0] msg_in, vis_q, vis_d, bak_q;
  logic             data_upd_q, bak_full, ovr_q;
  logic             vis_full_d, bak_full_d, bak_load, ovr_set;
  vis_sel_e         vis_sel;

  assign msg_in = {wr_len_i, wr_id_i, wr_data_i};

  mbx_disposition #(.TWO_DEEP(TWO_DEEP)) u_disp (
    .vis_full_i  (data_upd_q),
    .bak_full_i  (bak_full),
    .rel_i       (release_i),
    .wr_i        (wr_valid_i),
    .ovr_en_i    (ovr_en_i),
    .vis_sel_o   (vis_sel),
    .bak_load_o  (bak_load),
    .vis_full_d_o(vis_full_d),
    .bak_full_d_o(bak_full_d),
    .ovr_set_o   (ovr_set)
  );

  always_comb begin
    unique case (vis_sel)
      VIS_BAK: vis_d = bak_q;
      VIS_NEW: vis_d = msg_in;
      default: vis_d = vis_q;
    endcase
  end

  mbx_slot #(.W(MSG_W)) u_vis (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(vis_sel != VIS_HOLD),
    .d_i   (vis_d),
    .q_o   (vis_q)
  );

  generate
    if (TWO_DEEP) begin : g_backup
      logic bak_full_q;
      mbx_slot #(.W(MSG_W)) u_bak (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(bak_load),
        .d_i   (msg_in),
        .q_o   (bak_q)
      );
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bak_full_q <= 1'b0;
        else         bak_full_q <= bak_full_d;
      end
      assign bak_full = bak_full_q;
    end else begin : g_single
      logic unused_bak;
      assign unused_bak = bak_load ^ bak_full_d;
      assign bak_q      = '0;
      assign bak_full   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_upd_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      data_upd_q <= vis_full_d;
      ovr_q      <= ovr_set | (ovr_q & ~release_i);
    end
  end

  assign {rd_len_o, rd_id_o, rd_data_o} = vis_q;
  assign data_upd_o = data_upd_q;
  assign rx_ovr_o   = ovr_q;

  assert_empty_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !data_upd_o && !release_i |=> data_upd_o && rd_id_o == $past(wr_id_i));

  assert_promote_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i && bak_full |=> data_upd_o);

  assert_release_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i && !bak_full && !wr_valid_i |=> !data_upd_o);

  assert_vis_protected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    TWO_DEEP && data_upd_o && !release_i |=> $stable(rd_id_o) && $stable(rd_data_o) && $stable(rd_len_o));

  assert_ovr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> !rx_ovr_o);

  assert_ovr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_o && !release_i |=> rx_ovr_o);

  assert_single_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !TWO_DEEP && data_upd_o && wr_valid_i && !ovr_en_i && !release_i
      |=> $stable(rd_id_o) && $stable(rd_data_o) && data_upd_o);
endmodule

// File: tb/rx_mailbox2_tb.sv
`timescale 1ns/1ps
module rx_mailbox2_tb;
  localparam int ID_W = 11;
  localparam int DB   = 2;
  localparam int DW   = 8 * DB;
  localparam int LW   = $clog2(DB + 1);
  localparam int MW   = LW + ID_W + DW;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          wr, oe, rel;
  logic [ID_W-1:0] wid;
  logic [LW-1:0] wlen;
  logic [DW-1:0] wdat;
  logic [ID_W-1:0] id_a, id_b;
  logic [LW-1:0] len_a, len_b;
  logic [DW-1:0] dat_a, dat_b;
  logic upd_a, upd_b, ovr_a, ovr_b;

  rx_mailbox2 #(.ID_W(ID_W), .DATA_BYTES(DB), .TWO_DEEP(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr), .wr_id_i(wid), .wr_len_i(wlen),
    .wr_data_i(wdat), .ovr_en_i(oe), .release_i(rel), .rd_id_o(id_a), .rd_len_o(len_a),
    .rd_data_o(dat_a), .data_upd_o(upd_a), .rx_ovr_o(ovr_a));

  rx_mailbox2 #(.ID_W(ID_W), .DATA_BYTES(DB), .TWO_DEEP(1'b0)) u_dut_single (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr), .wr_id_i(wid), .wr_len_i(wlen),
    .wr_data_i(wdat), .ovr_en_i(oe), .release_i(rel), .rd_id_o(id_b), .rd_len_o(len_b),
    .rd_data_o(dat_b), .data_upd_o(upd_b), .rx_ovr_o(ovr_b));

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // model state, index 0 = two-deep, 1 = single
  logic [MW-1:0] m_vis [2];
  logic [MW-1:0] m_bak [2];
  logic m_vf [2], m_bf [2], m_ovr [2];
  string tag [2];

  task automatic model_step(input int m, input logic [MW-1:0] msg);
    logic vf, bf;
    vf = m_vf[m]; bf = m_bf[m];
    tag[m] = "R8";
    if (rel) begin
      m_ovr[m] = 1'b0;
      if (bf) begin m_vis[m] = m_bak[m]; vf = 1'b1; tag[m] = "R4"; end
      else begin vf = 1'b0; tag[m] = "R5"; end
      bf = 1'b0;
    end
    if (wr) begin
      if (rel) tag[m] = "R9";
      if (!vf) begin
        m_vis[m] = msg; vf = 1'b1;
        if (!rel) tag[m] = "R2";
      end else if (m == 0) begin
        if (!bf) begin
          m_bak[m] = msg; bf = 1'b1;
          if (!rel) tag[m] = "R3";
        end else begin
          if (oe) begin m_bak[m] = msg; m_ovr[m] = 1'b1; end
          if (!rel) tag[m] = oe ? "R7" : "R6";
        end
      end else begin
        if (oe) begin m_vis[m] = msg; m_ovr[m] = 1'b1; end
        tag[m] = "R10";
      end
    end
    m_vf[m] = vf; m_bf[m] = bf;
  endtask

  task automatic check(input int m, input string t);
    logic [MW-1:0] act;
    logic au, ao;
    act = (m == 0) ? {len_a, id_a, dat_a} : {len_b, id_b, dat_b};
    au  = (m == 0) ? upd_a : upd_b;
    ao  = (m == 0) ? ovr_a : ovr_b;
    n_run++;
    if (act !== m_vis[m] || au !== m_vf[m] || ao !== m_ovr[m]) begin
      n_fail++;
      $display("FAIL %s mode%0d: msg=%h upd=%b ovr=%b expected msg=%h upd=%b ovr=%b",
               t, m, act, au, ao, m_vis[m], m_vf[m], m_ovr[m]);
    end
  endtask

  initial begin
    wr = 0; oe = 0; rel = 0; wid = '0; wlen = '0; wdat = '0;
    for (int m = 0; m < 2; m++) begin
      m_vis[m] = '0; m_bak[m] = '0; m_vf[m] = 0; m_bf[m] = 0; m_ovr[m] = 0;
    end
    #20 rst_ni = 1'b1;
    @(negedge clk);
    check(0, "R1"); check(1, "R1");
    for (int i = 0; i < 3000; i++) begin
      int h;
      h = (i * 37 + (i >> 3) * 11 + 5) % 97;
      wr   = (h % 4) != 0;
      rel  = (h % 5) == 1 || (h % 7) == 3;
      oe   = ((h >> 2) & 1) == 1;
      wid  = ID_W'(i * 29 + 3);
      wlen = LW'(i % 3);
      wdat = DW'(i * 16'h3b1 + 7);
      model_step(0, {wlen, wid, wdat});
      model_step(1, {wlen, wid, wdat});
      @(negedge clk);
      check(0, tag[0]);
      check(1, tag[1]);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule